// File: doc/BRIEF.md
# RS-485 Driver-Enable Turnaround Controller

This block generates the driver-enable (direction) signal for an RS-485 transceiver that sits behind a UART transmitter. The block asserts the signal whenever the transmitter reports data waiting to go out. Once the final stop bit has left the transmitter, the block keeps the driver enabled for a programmable number of baud periods. Only then does it hand the bus back to the receive side. This hold time lets the far end and the line settle before the local driver turns off.

The hold is loaded from an 8-bit setting, giving 0 to 255 bit times. It is counted in baud ticks, not system clocks. A polarity control selects the active level of the pin. An override input forces the driver on regardless of the automatic logic. The UART shifter, its FIFOs and the analog transceiver are outside this block.

All state, including the pin itself, is registered on the system clock. The output reflects the inputs sampled at the same edge that updates the internal state.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, that edge clears the hold counter and drives `dir_out` to the inactive level of the current polarity: 1 when `invert` is 0, 0 when `invert` is 1.
- R2: A clock edge at which `tx_pending` is high leaves `dir_out` at the active level, with no extra cycle of latency.
- R3: The active level of `dir_out` is 0 when `invert` is 0 and 1 when `invert` is 1; the inactive level is the complement.
- R4: When `stop_done` is seen without `tx_pending` while the driver is enabled and the hold value N is non-zero, `dir_out` goes inactive at the edge of the N-th `baud_tick` after the `stop_done` cycle. A tick in the `stop_done` cycle itself is not counted.
- R5: With a hold value of 0, `dir_out` goes inactive at the very edge that samples `stop_done`.
- R6: `tx_pending` high during a hold countdown cancels it and keeps `dir_out` active. A later `stop_done` starts a fresh countdown.
- R7: While `ovr_en` is high, `dir_out` is at the active level, above every other input.
- R8: `baud_tick` has no effect on `dir_out` when no countdown is running. `stop_done` arriving while the driver is already released is ignored.
- R9: The hold value is captured when `stop_done` is sampled. Changes to `hold_bits` during the countdown do not alter the release time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pending | input | 1 | Transmit data is waiting or being shifted |
| stop_done | input | 1 | One-cycle strobe: last stop bit has left the transmitter |
| baud_tick | input | 1 | One-cycle strobe per bit period |
| hold_bits | input | HOLD_W (8) | Turnaround hold in bit times |
| invert | input | 1 | 1 selects an active-high direction pin |
| ovr_en | input | 1 | Forces the driver enabled |
| dir_out | output | 1 | Registered direction / driver-enable pin |

## Verification
The bench targets three corner cases: a zero hold, and the full 255-tick hold with ticks spread out. It also checks a tick that lands in the same cycle as `stop_done`. A design that counts that tick releases one bit early. A design that loads N-1 or N+1 releases a bit early or late. Another stimulus changes `hold_bits` mid-countdown; a design that compares against the live setting releases at the wrong time. Further cases cover new data arriving during the hold, stray `stop_done` strobes while idle, and override pulses across every state. They catch a design that leaves the pin stuck active or drops it while data is still pending. A polarity flip during reset shows whether the inactive level follows `invert`.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;
  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;
endpackage

// File: rtl/rs485_hold_timer.sv
module rs485_hold_timer #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic [HOLD_W-1:0] load_val,
  input  logic              tick_en,
  output logic              expire
);
  localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick_en && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expire = tick_en && (cnt_q == ONE);
endmodule

// File: rtl/rs485_dir_fsm.sv
module rs485_dir_fsm
  import rs485_dir_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_pending,
  input  logic              stop_done,
  input  logic              baud_tick,
  input  logic [HOLD_W-1:0] hold_bits,
  input  logic              expire,
  output logic              tmr_clr,
  output logic              tmr_load,
  output logic              tmr_tick,
  output logic              busy_nxt
);
  dir_state_e st_q, st_d;
  logic       hold_zero;

  assign hold_zero = (hold_bits == '0);

  always_comb begin
    st_d     = st_q;
    tmr_clr  = 1'b0;
    tmr_load = 1'b0;
    unique case (st_q)
      DIR_IDLE: begin
        if (tx_pending) st_d = DIR_SEND;
      end
      DIR_SEND, DIR_HOLD: begin
        if (tx_pending) begin
          st_d    = DIR_SEND;
          tmr_clr = 1'b1;
        end else if (stop_done) begin
          if (hold_zero) begin
            st_d    = DIR_IDLE;
            tmr_clr = 1'b1;
          end else begin
            st_d     = DIR_HOLD;
            tmr_load = 1'b1;
          end
        end else if (st_q == DIR_HOLD && expire) begin
          st_d = DIR_IDLE;
        end
      end
      default: st_d = DIR_IDLE;
    endcase
  end

  assign tmr_tick = baud_tick && (st_q == DIR_HOLD);
  assign busy_nxt = (st_d != DIR_IDLE);

  always_ff @(posedge clk) begin
    if (rst) st_q <= DIR_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/rs485_dir_drive.sv
module rs485_dir_drive (
  input  logic clk,
  input  logic rst,
  input  logic want_on,
  input  logic force_on,
  input  logic invert,
  output logic pin_q
);
  logic on_lvl;

  assign on_lvl = invert;

  always_ff @(posedge clk) begin
    if (rst)                     pin_q <= ~on_lvl;
    else if (force_on || want_on) pin_q <= on_lvl;
    else                         pin_q <= ~on_lvl;
  end
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_pending,
  input  logic              stop_done,
  input  logic              baud_tick,
  input  logic [HOLD_W-1:0] hold_bits,
  input  logic              invert,
  input  logic              ovr_en,
  output logic              dir_out
);
  logic tmr_clr, tmr_load, tmr_tick, expire, busy_nxt;

  rs485_dir_fsm #(.HOLD_W(HOLD_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .tx_pending(tx_pending),
    .stop_done (stop_done),
    .baud_tick (baud_tick),
    .hold_bits (hold_bits),
    .expire    (expire),
    .tmr_clr   (tmr_clr),
    .tmr_load  (tmr_load),
    .tmr_tick  (tmr_tick),
    .busy_nxt  (busy_nxt)
  );

  rs485_hold_timer #(.HOLD_W(HOLD_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clr     (tmr_clr),
    .load    (tmr_load),
    .load_val(hold_bits),
    .tick_en (tmr_tick),
    .expire  (expire)
  );

  rs485_dir_drive u_drv (
    .clk     (clk),
    .rst     (rst),
    .want_on (busy_nxt),
    .force_on(ovr_en),
    .invert  (invert),
    .pin_q   (dir_out)
  );
endmodule

// File: rtl/rs485_dir_ctrl_chk.sv
module rs485_dir_ctrl_chk #(
  parameter int HOLD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_pending,
  input logic              stop_done,
  input logic              baud_tick,
  input logic [HOLD_W-1:0] hold_bits,
  input logic              invert,
  input logic              ovr_en,
  input logic              dir_out
);
  // R1: reset edge leaves the pin at the inactive level
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (dir_out == !$past(invert)));

  // R2 / R3: pending data gives the active level one edge later
  assert_pending_active_R2: assert property (@(posedge clk) disable iff (rst)
    tx_pending |=> (dir_out == $past(invert)));

  // R7: override wins over everything
  assert_override_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ovr_en |=> (dir_out == $past(invert)));

  // R5: zero hold releases at the stop edge
  assert_zero_hold_release_R5: assert property (@(posedge clk) disable iff (rst)
    (stop_done && !tx_pending && !ovr_en && hold_bits == '0)
      |=> (dir_out == !$past(invert)));

  // R8: with no tick, no strobe, no data, no override change, the pin holds
  assert_quiet_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (!tx_pending && !stop_done && !baud_tick && !ovr_en && !$past(ovr_en)
      && invert == $past(invert))
      |=> (dir_out == $past(dir_out)));
endmodule

bind rs485_dir_ctrl rs485_dir_ctrl_chk #(.HOLD_W(HOLD_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_pending(tx_pending),
  .stop_done (stop_done),
  .baud_tick (baud_tick),
  .hold_bits (hold_bits),
  .invert    (invert),
  .ovr_en    (ovr_en),
  .dir_out   (dir_out)
);

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;
  localparam int HW = 8;

  logic          clk = 1'b0;
  logic          rst, tx_pending, stop_done, baud_tick, invert, ovr_en;
  logic [HW-1:0] hold_bits;
  logic          dir_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // spec model
  int          m_st;   // 0 idle, 1 send, 2 hold
  int          m_cnt;
  logic        m_exp;

  always #10 clk = ~clk;

  rs485_dir_ctrl #(.HOLD_W(HW)) u_dut (
    .clk(clk), .rst(rst), .tx_pending(tx_pending), .stop_done(stop_done),
    .baud_tick(baud_tick), .hold_bits(hold_bits), .invert(invert),
    .ovr_en(ovr_en), .dir_out(dir_out)
  );

  function automatic logic lvl(input logic on, input logic inv);
    return on ? inv : ~inv;
  endfunction

  task automatic model_step(output string tag);
    tag = "R4";
    if (rst) begin
      m_st = 0; m_cnt = 0; tag = "R1";
    end else if (m_st == 0) begin
      if (tx_pending) begin m_st = 1; tag = "R2"; end
      else tag = "R8";
    end else begin
      if (tx_pending) begin
        if (m_st == 2) tag = "R6"; else tag = "R2";
        m_st = 1; m_cnt = 0;
      end else if (stop_done) begin
        if (hold_bits == 0) begin m_st = 0; m_cnt = 0; tag = "R5"; end
        else begin m_st = 2; m_cnt = hold_bits; tag = "R9"; end
      end else if (m_st == 2 && baud_tick) begin
        if (m_cnt == 1) m_st = 0;
        m_cnt = m_cnt - 1;
      end
    end
    if (rst) m_exp = ~invert;
    else begin
      m_exp = lvl(ovr_en || m_st != 0, invert);
      if (ovr_en) tag = "R7";
    end
    if (invert && !rst && !ovr_en && m_st == 1) tag = "R3";
  endtask

  task automatic cyc();
    string tag;
    @(posedge clk);
    model_step(tag);
    #2;
    n_chk++;
    if (dir_out !== m_exp) begin
      n_bad++;
      $display("FAIL %s: dir_out=%b expected=%b at %0t", tag, dir_out, m_exp, $time);
    end
  endtask

  task automatic drv(input logic p, input logic s, input logic t);
    tx_pending = p; stop_done = s; baud_tick = t;
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      drv(0, 0, 1); cyc();
      for (int g = 0; g < gap; g++) begin drv(0, 0, 0); cyc(); end
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'h1f2e3d4c;
    void'($urandom(seed));
    m_st = 0; m_cnt = 0; m_exp = 1'b1;
    rst = 1; invert = 0; ovr_en = 0; hold_bits = 0;
    drv(0, 0, 0);
    cyc(); cyc();                       // R1 with normal polarity
    invert = 1; cyc();                  // R1 inverted polarity
    invert = 0; rst = 0; cyc();

    // R8: ticks and stray stop while idle
    ticks(3, 0); drv(0, 1, 1); cyc(); drv(0, 0, 0); cyc();

    // R5: zero hold
    hold_bits = 0; drv(1, 0, 0); cyc(); cyc(); drv(0, 0, 0); cyc();
    drv(0, 1, 1); cyc(); drv(0, 0, 0); cyc();

    // R4: hold 3, tick on the stop cycle not counted
    hold_bits = 3; drv(1, 0, 0); cyc(); drv(0, 1, 1); cyc(); ticks(4, 1);

    // R9: change hold mid-count
    hold_bits = 5; drv(1, 0, 0); cyc(); drv(0, 1, 0); cyc();
    hold_bits = 1; ticks(2, 0); hold_bits = 200; ticks(4, 2);

    // R6: cancel mid-count, restart
    hold_bits = 4; drv(1, 0, 0); cyc(); drv(0, 1, 0); cyc(); ticks(2, 0);
    drv(1, 0, 1); cyc(); ticks(3, 0); drv(0, 1, 0); cyc(); ticks(5, 0);

    // R7: override across states
    ovr_en = 1; ticks(3, 0); drv(1, 0, 0); cyc(); drv(0, 1, 0); cyc();
    ticks(6, 0); ovr_en = 0; ticks(2, 0);

    // R3: inverted polarity, full 255 hold with spread ticks
    invert = 1; hold_bits = 8'hFF; drv(1, 0, 0); cyc(); cyc();
    drv(0, 1, 1); cyc(); ticks(256, 2);

    // random mix
    for (int i = 0; i < 30000; i++) begin
      drv(($urandom % 8) == 0, ($urandom % 12) == 0, ($urandom % 3) == 0);
      if (($urandom % 60) == 0) ovr_en = ~ovr_en;
      if (($urandom % 300) == 0) invert = ~invert;
      if (($urandom % 20) == 0) hold_bits = (($urandom % 4) == 0) ? HW'($urandom) : HW'($urandom % 6);
      rst = (($urandom % 5000) == 0);
      cyc();
    end
    rst = 0; ovr_en = 0;
    drv(0, 0, 0); cyc();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule